// File: doc/BRIEF.md
# Clock Fault Glitch Pulse Generator

This block produces short fault pulses inside chosen cycles of a reference clock, either merged into that clock or driven out on their own. Two phase-shifted copies of the reference clock arrive from outside. The first copy sets where the pulse starts within a cycle. The second copy sets where it ends. A per-cycle enable register gates the pulse, so it appears only in the selected cycles.

A sequence starts on a rising edge of the trigger input or, when the manual source is selected, on a manual strobe. The block then waits a programmable number of reference-clock cycles. After the wait, it enables the pulse for a programmable number of consecutive cycles. A free-running counter reports how many glitch cycles have been issued since reset. Configuration is presented as plain parallel inputs. The offset and repeat values are captured when a sequence starts.

Top module: `clk_fault_pulser`

## Requirements
- R1: `cfg_mode` selects how the pulse is combined with the clock. 0 means `clk_out` = clk XOR pulse. 1 means `clk_out` = clk OR pulse. 2 means `clk_out` = pulse. 3 is enable-only: `clk_out` carries the whole-cycle enable. `glitch_raw` carries the pulse in modes 0 to 2 and the enable in mode 3.
- R2: The pulse is high only while `ph_start` is high, `ph_end` is low, and the per-cycle enable is set.
- R3: A start accepted at clock edge k with captured offset N raises the enable at edge k+N. N=0 raises it at edge k itself. The offset is 32 bits wide.
- R4: With captured repeat count R (1 to 8192), the enable stays high for exactly R consecutive cycles. A requested count above 8192 is treated as 8192.
- R5: A repeat count of 0 produces no pulse. The block is immediately ready for the next start.
- R6: With `cfg_src_manual`=0, a start is a 0-to-1 change of `trig_in` between two edges. A level held high starts nothing further.
- R7: With `cfg_src_manual`=1, a start is `man_strobe` high at an edge, and `trig_in` has no effect. With `cfg_src_manual`=0, `man_strobe` has no effect.
- R8: Starts that arrive while a sequence is waiting or glitching are ignored.
- R9: `pulse_count` is 0 after reset. It rises by exactly one for every enabled cycle.
- R10: After reset no sequence runs. The enable and `glitch_raw` are low, and `clk_out` in mode 0 follows the clock.
- R11: `cfg_offset` and `cfg_repeat` are captured when a sequence starts. Later changes do not affect that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ph_start | input | 1 | Phase-shifted clock setting the pulse start |
| ph_end | input | 1 | Phase-shifted clock setting the pulse end |
| trig_in | input | 1 | External trigger, rising edge starts a sequence |
| man_strobe | input | 1 | Manual start strobe |
| cfg_src_manual | input | 1 | 1 selects the manual strobe as start source |
| cfg_mode | input | 2 | Output combining mode |
| cfg_offset | input | 32 | Cycles from start to first glitch cycle |
| cfg_repeat | input | 14 | Number of consecutive glitch cycles |
| clk_out | output | 1 | Clock with the glitch combined in |
| glitch_raw | output | 1 | Bare pulse, or enable in enable-only mode |
| pulse_count | output | 32 | Total glitch cycles issued |

## Verification
On every cycle, the assertions check the following behaviours. The pulse never appears without the enable. The stored repeat value never exceeds 8192. The pulse count never decreases. A zero repeat leaves the block idle. A running sequence never falls back into its waiting phase. In automatic source mode, the block leaves idle only on a trigger edge. The bench scenarios show how many cycles the enable stays high and where it sits relative to the start. They also show the four output shapes sampled inside and outside the pulse window, re-triggers ignored mid-sequence, captured configuration surviving later changes, and the repeat clamp.

// File: rtl/clk_fault_pulser.sv
module clk_fault_pulser #(
  parameter int OFS_W   = 32,
  parameter int REP_MAX = 8192,
  parameter int REP_W   = 14,
  parameter int CNT_W   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ph_start,
  input  logic             ph_end,
  input  logic             trig_in,
  input  logic             man_strobe,
  input  logic             cfg_src_manual,
  input  logic [1:0]       cfg_mode,
  input  logic [OFS_W-1:0] cfg_offset,
  input  logic [REP_W-1:0] cfg_repeat,
  output logic             clk_out,
  output logic             glitch_raw,
  output logic [CNT_W-1:0] pulse_count
);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_GLITCH} state_t;

  state_t           state;
  logic             trig_q;
  logic             en_q;
  logic [OFS_W-1:0] dly;
  logic [REP_W-1:0] rep;

  wire              trig_edge = trig_in & ~trig_q;
  wire              fire      = cfg_src_manual ? man_strobe : trig_edge;
  wire [REP_W-1:0]  rep_req   = (cfg_repeat > REP_W'(REP_MAX)) ? REP_W'(REP_MAX) : cfg_repeat;
  wire              pulse     = ph_start & ~ph_end & en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      trig_q      <= 1'b1;
      en_q        <= 1'b0;
      dly         <= '0;
      rep         <= '0;
      pulse_count <= '0;
    end else begin
      trig_q      <= trig_in;
      pulse_count <= pulse_count + CNT_W'(en_q);
      case (state)
        S_IDLE:
          if (fire && rep_req != '0) begin
            rep <= rep_req;
            if (cfg_offset == '0) begin
              en_q  <= 1'b1;
              state <= S_GLITCH;
            end else begin
              dly   <= cfg_offset;
              state <= S_WAIT;
            end
          end
        S_WAIT:
          if (dly == OFS_W'(1)) begin
            en_q  <= 1'b1;
            state <= S_GLITCH;
          end else begin
            dly <= dly - OFS_W'(1);
          end
        S_GLITCH:
          if (rep == REP_W'(1)) begin
            en_q  <= 1'b0;
            state <= S_IDLE;
          end else begin
            rep <= rep - REP_W'(1);
          end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (cfg_mode)
      2'd0:    clk_out = clk ^ pulse;
      2'd1:    clk_out = clk | pulse;
      2'd2:    clk_out = pulse;
      default: clk_out = en_q;
    endcase
  end

  assign glitch_raw = (cfg_mode == 2'd3) ? en_q : pulse;

  p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && cfg_mode != 2'd3) |-> !glitch_raw);

  p_rep_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rep <= REP_W'(REP_MAX));

  p_zero_rep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && fire && rep_req == '0) |=> (state == S_IDLE && !en_q));

  p_auto_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !cfg_src_manual && !trig_edge) |=> state == S_IDLE);

  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_GLITCH |=> state != S_WAIT);

  p_count_mono_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> pulse_count >= $past(pulse_count));

endmodule

// File: tb/clk_fault_pulser_bench.sv
`timescale 1ns/1ps
module clk_fault_pulser_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ph_start, ph_end;
  logic        trig_in = 1'b0, man_strobe = 1'b0, cfg_src_manual = 1'b0;
  logic [1:0]  cfg_mode = 2'd0;
  logic [31:0] cfg_offset = '0;
  logic [13:0] cfg_repeat = '0;
  logic        clk_out, glitch_raw;
  logic [31:0] pulse_count;
  int          n_cmp = 0, n_bad = 0;
  bit          done = 0;

  always #10 clk = ~clk;
  assign #2 ph_start = clk;
  assign #5 ph_end   = clk;

  clk_fault_pulser u_clk_fault_pulser (
    .clk(clk), .rst_n(rst_n), .ph_start(ph_start), .ph_end(ph_end),
    .trig_in(trig_in), .man_strobe(man_strobe), .cfg_src_manual(cfg_src_manual),
    .cfg_mode(cfg_mode), .cfg_offset(cfg_offset), .cfg_repeat(cfg_repeat),
    .clk_out(clk_out), .glitch_raw(glitch_raw), .pulse_count(pulse_count));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int clamp_rep(input int r);
    return (r > 8192) ? 8192 : r;
  endfunction

  function automatic bit exp_out_in(input bit [1:0] m, input bit e);
    case (m)
      2'd0: return ~e;
      2'd1: return 1'b1;
      default: return e;
    endcase
  endfunction

  function automatic bit exp_out_late(input bit [1:0] m, input bit e);
    case (m)
      2'd0, 2'd1: return 1'b1;
      2'd2: return 1'b0;
      default: return e;
    endcase
  endfunction

  // kind 0: trig edge, auto src; 1: strobe, manual src; 2: strobe, auto src; 3: trig edge, manual src
  task automatic run_seq(input int n, input int r, input int kind, input bit [1:0] m, input bit retrig);
    int  re   = clamp_rep(r);
    bit  fire = (kind < 2) && (re > 0);
    bit  rt   = retrig && kind < 2 && re >= 1 && (n + re) >= 3;
    logic [31:0] cnt0;
    @(negedge clk);
    trig_in = 0; man_strobe = 0;
    cfg_src_manual = (kind == 1 || kind == 3);
    cfg_mode = m; cfg_offset = n; cfg_repeat = 14'(r);
    @(negedge clk);
    cnt0 = pulse_count;
    if (kind == 1 || kind == 2) man_strobe = 1; else trig_in = 1;
    for (int j = 0; j <= n + re + 2; j++) begin
      bit e;
      e = fire && j >= n && j < n + re;
      @(posedge clk);
      #3.5;
      chk($sformatf("R3 R4 R6 R7 en j=%0d", j), 32'(glitch_raw), 32'(e));
      chk($sformatf("R1 R2 clk_out in-window m=%0d j=%0d", m, j), 32'(clk_out), 32'(exp_out_in(m, e)));
      #5;
      chk($sformatf("R1 R2 clk_out late m=%0d j=%0d", m, j), 32'(clk_out), 32'(exp_out_late(m, e)));
      @(negedge clk);
      man_strobe = 0;
      if (j == 0) begin
        cfg_offset = $urandom_range(0, 3);
        cfg_repeat = 14'($urandom_range(0, 3));
      end
      if (rt && j == 0 && kind == 0) trig_in = 0;
      if (rt && j == 1) begin
        if (kind == 0) trig_in = 1; else man_strobe = 1;
      end
    end
    chk($sformatf("R9 R11 R8 R5 count n=%0d r=%0d kind=%0d", n, r, kind),
        pulse_count - cnt0, fire ? 32'(re) : 32'd0);
    @(negedge clk);
    trig_in = 0; man_strobe = 0;
  endtask

  initial begin
    #(20.0 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(posedge clk); #3.5;
    chk("R10 reset count", pulse_count, 0);
    chk("R10 reset glitch_raw", 32'(glitch_raw), 0);
    chk("R10 reset clk_out", 32'(clk_out), 1);
    run_seq(0, 1, 0, 2'd2, 0);
    run_seq(1, 3, 0, 2'd0, 0);
    run_seq(4, 0, 0, 2'd2, 0);
    run_seq(0, 0, 1, 2'd2, 0);
    run_seq(0, 2, 0, 2'd2, 0);
    run_seq(2, 5, 0, 2'd1, 1);
    run_seq(3, 4, 1, 2'd3, 1);
    run_seq(2, 3, 2, 2'd2, 0);
    run_seq(2, 3, 3, 2'd2, 0);
    run_seq(700, 5, 0, 2'd0, 1);
    run_seq(3, 9000, 0, 2'd2, 0);
    run_seq(1, 8192, 1, 2'd3, 0);
    for (int i = 0; i < 40; i++)
      run_seq($urandom_range(0, 25), $urandom_range(0, 40), $urandom_range(0, 3),
              2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule